// File: doc/BRIEF.md
# Dual Programmable Blink Generator with Pin Source Select

This block makes two independent blink waveforms and steers them onto a pair of open-drain LED pins. Each waveform has its own 8-bit rate value and 8-bit duty threshold. A base tick enable sets the time scale, nominally 44 × 256 pulses per second. Each waveform walks a 256-step phase counter. The counter advances once every (rate + 1) base ticks, so a full blink lasts (rate + 1)/44 s, which spans about 0.023 s to 5.82 s.

The duty threshold splits every period into an off part and an on part. The LED is on while the phase is at or above the threshold, which gives an on fraction of (256 − threshold)/256. A threshold of zero keeps the LED dark. Rate and duty values are copied into working registers only when the phase counter wraps, so a blink that is already running never produces a shortened pulse.

A 2-bit source code per pin picks one of four drives for that pin: pulled low, released, blink 0 or blink 1. The level seen on each external pin is registered and returned, so a released pin can also serve as a general input. A register file elsewhere supplies the rate, duty and source values; this block only consumes them.

Top module: `dual_blink_top`

## Requirements
- R1: The phase counter of each channel advances by one every (rate + 1) asserted base ticks. A full blink period is therefore (rate + 1) × 256 base ticks, and the first on sample after a wrap falls at tick duty × (rate + 1).
- R2: `blink_on[n]` is 1 (LED on) exactly while the phase counter of channel n is greater than or equal to its working duty value (when that value is nonzero). Over one period it is high for (256 − duty) × (rate + 1) ticks.
- R3: A working duty value of 0 keeps `blink_on[n]` at 0 for the whole period.
- R4: Pin i takes its source code from `pin_sel[2i+1:2i]`, so pin 0 uses bits 1:0 and pin 1 uses bits 3:2. The codes are:
  - 00: drive low, `pin_drive_low[i]` = 1.
  - 01: released, `pin_drive_low[i]` = 0.
  - 10: follows `blink_on[0]`.
  - 11: follows `blink_on[1]`.
- R5: While reset is asserted, the working rate and duty copy the inputs. After reset, a new rate or duty input value takes effect only when the phase goes from 255 back to 0.
- R6: With `base_tick` low, neither the prescaler nor the phase counter moves, and `blink_on` holds its value.
- R7: `pin_readback` equals the `pin_level` sampled at the previous clock edge.
- R8: Reset is synchronous and active high. It clears both counters, so `blink_on` is 0 directly after reset.
- R9: Rate 43 with duty 128 gives a 11264-tick period with 5632 on ticks. Rate 10 with duty 192 gives a 2816-tick period with 704 on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| base_tick | input | 1 | One-cycle enable at the base blink rate |
| rate0 | input | 8 | Prescaler value, channel 0 |
| duty0 | input | 8 | Duty threshold, channel 0 |
| rate1 | input | 8 | Prescaler value, channel 1 |
| duty1 | input | 8 | Duty threshold, channel 1 |
| pin_sel | input | 4 | Source code per pin, two bits each |
| pin_level | input | 2 | Level seen on each external pin |
| pin_drive_low | output | 2 | Open-drain pull-down enable per pin |
| blink_on | output | 2 | Raw blink waveforms, 1 = LED on |
| pin_readback | output | 2 | Registered pin levels |

## Verification
The bench aims at the following corner cases:

- **Duty zero.** A design that compared with a plain greater-or-equal would light the LED for the entire period instead of keeping it dark.
- **Rate or duty changed mid-period.** An immediate update would show up as a wrong on count in the period where the change was made.
- **Frozen tick.** If the counters kept moving while the tick enable was low, the cycle-by-cycle model would diverge at once.
- **Source codes.** Every source code is swept on both pins while the two blinks are known to differ. Swapped pin fields or swapped blink sources would then drive the wrong pin level.

// File: rtl/blinkgen_pkg.sv
package blinkgen_pkg;

    localparam int RATE_W  = 8;
    localparam int PHASE_W = 8;
    localparam int NUM_CH  = 2;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_SINK    = 2'b00,
        SRC_RELEASE = 2'b01,
        SRC_BLINK0  = 2'b10,
        SRC_BLINK1  = 2'b11
    } pin_src_e;

    typedef struct packed {
        logic [RATE_W-1:0]  rate;
        logic [PHASE_W-1:0] duty;
    } blink_cfg_t;

    function automatic logic src_drive(pin_src_e s, logic [NUM_CH-1:0] b);
        case (s)
            SRC_SINK:    return 1'b1;
            SRC_RELEASE: return 1'b0;
            SRC_BLINK0:  return b[0];
            default:     return b[1];
        endcase
    endfunction

endpackage

// File: rtl/blink_channel.sv
module blink_channel
    import blinkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  blink_cfg_t cfg_in,
    output logic       blink_on
);

    logic [RATE_W-1:0]  pre_cnt;
    logic [PHASE_W-1:0] phase;
    blink_cfg_t         act;
    logic               expire;
    logic               wrap;

    assign expire = base_tick && (pre_cnt == act.rate);
    assign wrap   = expire && (phase == {PHASE_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            phase   <= '0;
            act     <= cfg_in;
        end else if (base_tick) begin
            if (expire) begin
                pre_cnt <= '0;
                phase   <= phase + 1'b1;
                if (wrap) begin
                    act <= cfg_in;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        blink_on = (act.duty != '0) && (phase >= act.duty);
    end

    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        expire |=> (phase - $past(phase)) == PHASE_W'(1));

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
        !base_tick |=> $stable(phase) && $stable(pre_cnt));

    p_rise_at_duty_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(blink_on) |-> phase == act.duty);

    p_fall_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(blink_on) |-> phase == '0);

    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act));

endmodule

// File: rtl/pin_router.sv
module pin_router
    import blinkgen_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic [SEL_W*NUM_PINS-1:0] pin_sel,
    input  logic [NUM_CH-1:0]         blink,
    output logic [NUM_PINS-1:0]       drive_low
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_comb begin
            drive_low[i] = src_drive(pin_src_e'(pin_sel[SEL_W*i +: SEL_W]), blink);
        end
    end

endmodule

// File: rtl/dual_blink_top.sv
module dual_blink_top
    import blinkgen_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      base_tick,
    input  logic [RATE_W-1:0]         rate0,
    input  logic [PHASE_W-1:0]        duty0,
    input  logic [RATE_W-1:0]         rate1,
    input  logic [PHASE_W-1:0]        duty1,
    input  logic [SEL_W*NUM_PINS-1:0] pin_sel,
    input  logic [NUM_PINS-1:0]       pin_level,
    output logic [NUM_PINS-1:0]       pin_drive_low,
    output logic [NUM_CH-1:0]         blink_on,
    output logic [NUM_PINS-1:0]       pin_readback
);

    blink_cfg_t cfg [NUM_CH];

    assign cfg[0] = '{rate: rate0, duty: duty0};
    assign cfg[1] = '{rate: rate1, duty: duty1};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        blink_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .base_tick(base_tick),
            .cfg_in   (cfg[c]),
            .blink_on (blink_on[c])
        );
    end

    pin_router #(.NUM_PINS(NUM_PINS)) u_route (
        .pin_sel  (pin_sel),
        .blink    (blink_on),
        .drive_low(pin_drive_low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_readback <= '0;
        end else begin
            pin_readback <= pin_level;
        end
    end

    p_readback_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pin_readback == $past(pin_level));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_sel[1:0] == 2'b01) |-> !pin_drive_low[0]);

    p_reset_dark_r8: assert property (@(posedge clk)
        $fell(rst) |-> blink_on == '0);

endmodule

// File: tb/dual_blink_top_test.sv
module dual_blink_top_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b1;
    logic [7:0] rate0 = 8'd3, duty0 = 8'd128, rate1 = 8'd1, duty1 = 8'd192;
    logic [3:0] pin_sel = 4'b0101;
    logic [1:0] pin_level = 2'b00;
    logic [1:0] pin_drive_low, blink_on, pin_readback;

    int n_cmp = 0;
    int n_bad = 0;

    dual_blink_top uut (
        .clk(clk), .rst(rst), .base_tick(base_tick),
        .rate0(rate0), .duty0(duty0), .rate1(rate1), .duty1(duty1),
        .pin_sel(pin_sel), .pin_level(pin_level),
        .pin_drive_low(pin_drive_low), .blink_on(blink_on),
        .pin_readback(pin_readback)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference built from R1, R2, R3, R5, R6, R7
    int   m_pre [2];
    int   m_ph  [2];
    int   m_rate[2];
    int   m_duty[2];
    logic [1:0] m_rb;
    bit   run_chk = 0;

    function automatic bit exp_blink(int c);
        return (m_duty[c] != 0) && (m_ph[c] >= m_duty[c]);
    endfunction

    function automatic bit exp_drive(int code, bit b0, bit b1);
        case (code)
            0: return 1'b1;
            1: return 1'b0;
            2: return b0;
            default: return b1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_pre[c] = 0;
                m_ph[c]  = 0;
            end
            m_rate[0] = rate0; m_duty[0] = duty0;
            m_rate[1] = rate1; m_duty[1] = duty1;
            m_rb = 2'b00;
        end else begin
            m_rb = pin_level;
            if (base_tick) begin
                for (int c = 0; c < 2; c++) begin
                    if (m_pre[c] == m_rate[c]) begin
                        m_pre[c] = 0;
                        if (m_ph[c] == 255) begin
                            m_ph[c] = 0;
                            m_rate[c] = (c == 0) ? int'(rate0) : int'(rate1);
                            m_duty[c] = (c == 0) ? int'(duty0) : int'(duty1);
                        end else begin
                            m_ph[c] = m_ph[c] + 1;
                        end
                    end else begin
                        m_pre[c] = m_pre[c] + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (run_chk && !rst) begin
            for (int c = 0; c < 2; c++) begin
                chk(blink_on[c] == exp_blink(c), $sformatf("R2 ch%0d blink", c),
                    blink_on[c], exp_blink(c));
            end
            for (int p = 0; p < 2; p++) begin
                chk(pin_drive_low[p] == exp_drive(int'(pin_sel[2*p +: 2]), exp_blink(0), exp_blink(1)),
                    $sformatf("R4 pin%0d drive", p), pin_drive_low[p],
                    exp_drive(int'(pin_sel[2*p +: 2]), exp_blink(0), exp_blink(1)));
            end
            chk(pin_readback == m_rb, "R7 readback", pin_readback, m_rb);
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset(input int r0, input int d0, input int r1, input int d1);
        rate0 = 8'(r0); duty0 = 8'(d0); rate1 = 8'(r1); duty1 = 8'(d1);
        base_tick = 1'b1;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hi0, hi1, first0, dummy;
        bit held;
        dummy = $urandom(32'h5eed);
        pin_sel = 4'b0101;

        // R8: reset state
        do_reset(3, 128, 1, 192);
        run_chk = 1;
        @(negedge clk);
        chk(blink_on == 2'b00, "R8 blink after reset", blink_on, 0);
        chk(pin_drive_low == 2'b00, "R8 released pins", pin_drive_low, 0);

        // R9, R1: example settings, counted from a reset-aligned wrap
        step(1);
        do_reset(43, 128, 10, 192);
        hi0 = 0; hi1 = 0; first0 = -1;
        for (int k = 0; k < 11264; k++) begin
            @(negedge clk);
            if (blink_on[0]) begin
                hi0++;
                if (first0 < 0) first0 = k;
            end
            if (k < 2816 && blink_on[1]) hi1++;
        end
        chk(hi0 == 5632, "R9 ch0 on ticks", hi0, 5632);
        chk(hi1 == 704, "R9 ch1 on ticks", hi1, 704);
        chk(first0 == 128 * 44, "R1 first on tick", first0, 128 * 44);

        // R3: duty zero stays dark; duty one almost always on
        step(1);
        do_reset(0, 0, 0, 1);
        hi0 = 0; hi1 = 0;
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            hi0 += int'(blink_on[0]);
            hi1 += int'(blink_on[1]);
        end
        chk(hi0 == 0, "R3 duty zero on ticks", hi0, 0);
        chk(hi1 == 510, "R2 duty one on ticks", hi1, 510);

        // R5: duty change mid-period waits for the wrap
        step(1);
        do_reset(0, 128, 0, 64);
        hi0 = 0; hi1 = 0;
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            if (k < 256) hi0 += int'(blink_on[0]);
            else         hi1 += int'(blink_on[0]);
            if (k == 100) duty0 = 8'd16;
        end
        chk(hi0 == 128, "R5 old duty in current period", hi0, 128);
        chk(hi1 == 240, "R5 new duty after wrap", hi1, 240);

        // R6: no tick, no movement
        step(1);
        do_reset(0, 128, 0, 64);
        step(130);
        base_tick = 1'b0;
        held = 1'b1;
        @(negedge clk);
        hi0 = int'(blink_on);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (int'(blink_on) != hi0) held = 1'b0;
        end
        chk(held, "R6 blink frozen without tick", int'(blink_on), hi0);
        base_tick = 1'b1;

        // R4: sweep all source codes while blink0=1 and blink1=0
        step(1);
        do_reset(0, 1, 0, 255);
        step(5);
        for (int s = 0; s < 16; s++) begin
            pin_sel = 4'(s);
            @(negedge clk);
            chk(pin_drive_low[0] == exp_drive(s % 4, 1'b1, 1'b0), "R4 pin0 sweep",
                pin_drive_low[0], exp_drive(s % 4, 1'b1, 1'b0));
            chk(pin_drive_low[1] == exp_drive(s / 4, 1'b1, 1'b0), "R4 pin1 sweep",
                pin_drive_low[1], exp_drive(s / 4, 1'b1, 1'b0));
            step(1);
        end

        // Random traffic, checked cycle by cycle against the model (R1, R2, R3, R5, R6, R7)
        do_reset(2, 100, 1, 0);
        for (int k = 0; k < 30000; k++) begin
            base_tick = ($urandom % 4) != 0;
            pin_level = 2'($urandom);
            if (($urandom % 1500) == 0) begin
                rate0 = 8'($urandom % 4);
                duty0 = (($urandom % 4) == 0) ? 8'd0 : 8'($urandom);
            end
            if (($urandom % 1500) == 0) begin
                rate1 = 8'($urandom % 4);
                duty1 = (($urandom % 4) == 0) ? 8'd0 : 8'($urandom);
            end
            if (($urandom % 50) == 0) pin_sel = 4'($urandom);
            step(1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule